// File: doc/BRIEF.md
# Host FIFO and Mailbox Port

This block is the device-side register file behind an eight-address host I/O window. The host uses a data port to write an outbound FIFO and to read an inbound FIFO. It reads a status byte, writes an interrupt-enable byte, and exchanges six-bit messages through two single-entry mailboxes. On the device side the block offers a push port into the inbound FIFO, a pop port out of the outbound FIFO, and a put and take port on the mailboxes. The device side also has an arm strobe for the host interrupt.

With `WORD_MODE` set, each FIFO entry is sixteen bits wide. A word-wide access to the data port moves a whole entry. A byte-wide write takes its upper byte from a staging register loaded at offset 1. A byte-wide read returns only the lower byte and still consumes the entry. Any write to offset 7 flushes both FIFOs and both mailboxes, clears the enable byte, and withdraws the global interrupt enable. It also pulses a board reset strobe.

Top module: `host_mbox_port`

## Requirements
- R1: After `rst_n` the status byte (offset 2) reads 0x21, `irq` and `board_rst` are low, and both device mailbox flags are low.
- R2: Host writes at offset 0 enter the outbound FIFO and leave `dev_out_data` in write order. Status bit 0x01 marks the outbound FIFO empty, 0x10 marks its occupancy at or above half of `DEPTH`, and 0x40 marks it full.
- R3: Device pushes leave through host reads at offset 0 in push order. Status bit 0x20 marks the inbound FIFO empty, 0x08 marks occupancy at or above half, and 0x02 marks it full.
- R4: In word mode a word-wide (`host_wide`=1) data access moves 16 bits. A byte-wide write pushes {staging byte from offset 1, data byte}. A byte-wide read returns the low byte with the upper byte as zero, and the entry is still consumed.
- R5: A host write at offset 3 stores data bits 7..2 as the outbound mailbox and sets status bit 0x80. Only `dev_mb_rd` clears that bit.
- R6: `dev_mb_wr` fills the inbound mailbox and sets status bit 0x04. A host read at offset 3 returns {mailbox, 2'b00} and clears that bit. Bits 1..0 of a mailbox read are always 0.
- R7: When enable-byte bit 0x80 is set, a read at offset 3 returns the outbound mailbox and clears neither mailbox flag. When it is clear, the read returns the inbound mailbox.
- R8: `irq` is high when the global enable is set (by `dev_irq_arm`) and any enabled source is active. The enable-byte bits map to sources as follows: 0x40 to inbound mailbox full, 0x20 to inbound full, 0x08 to inbound empty, 0x04 to outbound full, and 0x01 to outbound empty.
- R9: Any write at offset 7 flushes both FIFOs and both mailboxes, zeroes the enable byte, and drops the global enable. `board_rst` pulses high for the one cycle after that write.
- R10: A read at offset 7 returns 0 and changes no state.
- R11: A host write into a full outbound FIFO is dropped. A pop from an empty FIFO changes nothing.
- R12: Unassigned enable-byte bits (0x02, 0x10) are stored as zero and never raise `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_addr | input | 3 | Host register offset |
| host_wdata | input | 16 | Host write data |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wide | input | 1 | Word-wide data access qualifier |
| host_rdata | output | 16 | Host read data, valid while `host_rd` is high |
| board_rst | output | 1 | One-cycle pulse after a write at offset 7 |
| dev_in_push | input | 1 | Device push into inbound FIFO |
| dev_in_data | input | FW | Inbound push data |
| dev_in_full | output | 1 | Inbound FIFO full |
| dev_out_pop | input | 1 | Device pop from outbound FIFO |
| dev_out_data | output | FW | Head of outbound FIFO |
| dev_out_empty | output | 1 | Outbound FIFO empty |
| dev_mb_wr | input | 1 | Device put into inbound mailbox |
| dev_mb_wdata | input | 6 | Inbound mailbox data |
| dev_mb_rd | input | 1 | Device take from outbound mailbox |
| dev_mb_rdata | output | 6 | Outbound mailbox contents |
| dev_mb_out_full | output | 1 | Outbound mailbox holds unread data |
| dev_mb_in_full | output | 1 | Inbound mailbox not yet read by host |
| dev_irq_arm | input | 1 | Sets the global interrupt enable |
| irq | output | 1 | Host interrupt |

## Verification
The bench builds the block with `DEPTH`=4 and `WORD_MODE`=1. With a depth of four, the half-full thresholds, the full flags and a dropped overflow write are each reached within a few accesses. The word-mode variant brings the staging register, the truncating byte read and the 16-bit data path into play. These sit beside the mailbox readback selection and the interrupt gating before and after a board reset.

// File: rtl/hmp_pkg.sv
package hmp_pkg;
  // status byte bit positions
  localparam int ST_OMB    = 7;
  localparam int ST_OFULL  = 6;
  localparam int ST_IEMPTY = 5;
  localparam int ST_OHALF  = 4;
  localparam int ST_IHALF  = 3;
  localparam int ST_IMB    = 2;
  localparam int ST_IFULL  = 1;
  localparam int ST_OEMPTY = 0;

  // enable byte bit positions
  localparam int MK_RSEL   = 7;
  localparam int MK_IMB    = 6;
  localparam int MK_IFULL  = 5;
  localparam int MK_IEMPTY = 3;
  localparam int MK_OFULL  = 2;
  localparam int MK_OEMPTY = 0;
  localparam logic [7:0] MK_LEGAL = 8'hED;

  // register offsets
  localparam logic [2:0] A_DATA = 3'd0;
  localparam logic [2:0] A_DHI  = 3'd1;
  localparam logic [2:0] A_STAT = 3'd2;
  localparam logic [2:0] A_MBOX = 3'd3;
  localparam logic [2:0] A_CTRL = 3'd7;

  // active interrupt sources: status bits routed through their enables
  function automatic logic [7:0] irq_sources(logic [7:0] st, logic [7:0] mk);
    logic [7:0] s;
    s = '0;
    s[6] = mk[MK_IMB]    & st[ST_IMB];
    s[5] = mk[MK_IFULL]  & st[ST_IFULL];
    s[3] = mk[MK_IEMPTY] & st[ST_IEMPTY];
    s[2] = mk[MK_OFULL]  & st[ST_OFULL];
    s[0] = mk[MK_OEMPTY] & st[ST_OEMPTY];
    return s;
  endfunction

  function automatic logic at_half(int unsigned cnt, int unsigned depth);
    return (cnt * 2) >= depth;
  endfunction
endpackage

// File: rtl/hmp_fifo.sv
module hmp_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push & ~full;
  assign pop_ok  = pop & ~empty;
  assign rdata   = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else if (flush) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (push_ok) wp <= bump(wp);
      if (pop_ok)  rp <= bump(rp);
      count <= count + CW'(push_ok) - CW'(pop_ok);
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok && !flush) mem[wp] <= wdata;
  end
endmodule

// File: rtl/hmp_mbox.sv
module hmp_mbox #(
  parameter int MW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          put,
  input  logic [MW-1:0] put_data,
  input  logic          take,
  output logic [MW-1:0] data,
  output logic          full
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data <= '0; full <= 1'b0;
    end else if (clear) begin
      data <= '0; full <= 1'b0;
    end else if (put) begin
      data <= put_data; full <= 1'b1;
    end else if (take) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/hmp_status.sv
module hmp_status
  import hmp_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input  logic [CW-1:0] in_cnt,
  input  logic [CW-1:0] out_cnt,
  input  logic          in_full,
  input  logic          in_empty,
  input  logic          out_full,
  input  logic          out_empty,
  input  logic          imb_full,
  input  logic          omb_full,
  input  logic [7:0]    mask,
  input  logic          glob_en,
  output logic [7:0]    stat,
  output logic          irq
);
  always_comb begin
    stat            = '0;
    stat[ST_OMB]    = omb_full;
    stat[ST_OFULL]  = out_full;
    stat[ST_IEMPTY] = in_empty;
    stat[ST_OHALF]  = at_half(int'(out_cnt), DEPTH);
    stat[ST_IHALF]  = at_half(int'(in_cnt), DEPTH);
    stat[ST_IMB]    = imb_full;
    stat[ST_IFULL]  = in_full;
    stat[ST_OEMPTY] = out_empty;
  end

  assign irq = glob_en & (|irq_sources(stat, mask));
endmodule

// File: rtl/host_mbox_port.sv
module host_mbox_port
  import hmp_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int WORD_MODE = 1,
  localparam int FW       = (WORD_MODE != 0) ? 16 : 8,
  localparam int CW       = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    host_addr,
  input  logic [15:0]   host_wdata,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic          host_wide,
  output logic [15:0]   host_rdata,
  output logic          board_rst,
  input  logic          dev_in_push,
  input  logic [FW-1:0] dev_in_data,
  output logic          dev_in_full,
  input  logic          dev_out_pop,
  output logic [FW-1:0] dev_out_data,
  output logic          dev_out_empty,
  input  logic          dev_mb_wr,
  input  logic [5:0]    dev_mb_wdata,
  input  logic          dev_mb_rd,
  output logic [5:0]    dev_mb_rdata,
  output logic          dev_mb_out_full,
  output logic          dev_mb_in_full,
  input  logic          dev_irq_arm,
  output logic          irq
);
  // named internal events
  logic host_push, host_pop, wr_hi, wr_mask, host_mb_put, host_mb_take, board_flush;
  logic [7:0]    mask_q;
  logic          glob_en;
  logic [7:0]    stat_byte;
  logic [CW-1:0] in_cnt, out_cnt;
  logic          in_empty, out_full;
  logic [FW-1:0] in_rdata, out_wdata;
  logic [15:0]   rd_word;
  logic [5:0]    imb_data;

  assign host_push    = host_wr & (host_addr == A_DATA);
  assign wr_hi        = host_wr & (host_addr == A_DHI);
  assign wr_mask      = host_wr & (host_addr == A_STAT);
  assign host_mb_put  = host_wr & (host_addr == A_MBOX);
  assign board_flush  = host_wr & (host_addr == A_CTRL);
  assign host_pop     = host_rd & (host_addr == A_DATA);
  assign host_mb_take = host_rd & (host_addr == A_MBOX) & ~mask_q[MK_RSEL];

  generate
    if (WORD_MODE != 0) begin : g_word
      logic [7:0] hi_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           hi_q <= '0;
        else if (board_flush) hi_q <= '0;
        else if (wr_hi)       hi_q <= host_wdata[7:0];
      end
      assign out_wdata = host_wide ? host_wdata : {hi_q, host_wdata[7:0]};
      assign rd_word   = host_wide ? in_rdata : {8'h00, in_rdata[7:0]};
    end else begin : g_byte
      assign out_wdata = host_wdata[7:0];
      assign rd_word   = {8'h00, in_rdata};
    end
  endgenerate

  hmp_fifo #(.W(FW), .DEPTH(DEPTH)) u_in_fifo (
    .clk(clk), .rst_n(rst_n), .flush(board_flush),
    .push(dev_in_push), .wdata(dev_in_data),
    .pop(host_pop), .rdata(in_rdata),
    .count(in_cnt), .full(dev_in_full), .empty(in_empty)
  );

  hmp_fifo #(.W(FW), .DEPTH(DEPTH)) u_out_fifo (
    .clk(clk), .rst_n(rst_n), .flush(board_flush),
    .push(host_push), .wdata(out_wdata),
    .pop(dev_out_pop), .rdata(dev_out_data),
    .count(out_cnt), .full(out_full), .empty(dev_out_empty)
  );

  hmp_mbox #(.MW(6)) u_out_mb (
    .clk(clk), .rst_n(rst_n), .clear(board_flush),
    .put(host_mb_put), .put_data(host_wdata[7:2]),
    .take(dev_mb_rd), .data(dev_mb_rdata), .full(dev_mb_out_full)
  );

  hmp_mbox #(.MW(6)) u_in_mb (
    .clk(clk), .rst_n(rst_n), .clear(board_flush),
    .put(dev_mb_wr), .put_data(dev_mb_wdata),
    .take(host_mb_take), .data(imb_data), .full(dev_mb_in_full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0; glob_en <= 1'b0; board_rst <= 1'b0;
    end else begin
      board_rst <= board_flush;
      if (board_flush) begin
        mask_q  <= '0;
        glob_en <= 1'b0;
      end else begin
        if (wr_mask)     mask_q  <= host_wdata[7:0] & MK_LEGAL;
        if (dev_irq_arm) glob_en <= 1'b1;
      end
    end
  end

  hmp_status #(.DEPTH(DEPTH), .CW(CW)) u_status (
    .in_cnt(in_cnt), .out_cnt(out_cnt),
    .in_full(dev_in_full), .in_empty(in_empty),
    .out_full(out_full), .out_empty(dev_out_empty),
    .imb_full(dev_mb_in_full), .omb_full(dev_mb_out_full),
    .mask(mask_q), .glob_en(glob_en),
    .stat(stat_byte), .irq(irq)
  );

  always_comb begin
    host_rdata = '0;
    unique case (host_addr)
      A_DATA:  host_rdata = in_empty ? 16'h0000 : rd_word;
      A_STAT:  host_rdata = {8'h00, stat_byte};
      A_MBOX:  host_rdata = {8'h00, (mask_q[MK_RSEL] ? dev_mb_rdata : imb_data), 2'b00};
      default: host_rdata = '0;
    endcase
  end
endmodule

// File: rtl/hmp_checker.sv
module hmp_checker #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    host_addr,
  input logic          host_wr,
  input logic          host_rd,
  input logic [15:0]   host_rdata,
  input logic          dev_in_push,
  input logic          dev_out_pop,
  input logic          dev_mb_wr,
  input logic          dev_mb_rd,
  input logic          glob_en,
  input logic          irq,
  input logic          board_rst,
  input logic [7:0]    stat_byte,
  input logic [CW-1:0] in_cnt,
  input logic [CW-1:0] out_cnt
);
  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_en |-> !irq);

  p_omb_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == 3'd3) |=> stat_byte[7]);

  p_omb_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_mb_rd && !(host_wr && host_addr == 3'd3)) |=> !stat_byte[7]);

  p_low_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == 3'd3) |-> host_rdata[1:0] == 2'b00);

  p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == 3'd7) |=> (stat_byte == 8'h21 && board_rst && !irq));

  p_nop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == 3'd7 && !host_wr && !dev_in_push && !dev_out_pop &&
     !dev_mb_wr && !dev_mb_rd) |=> $stable(stat_byte));

  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(in_cnt) <= DEPTH) && (32'(out_cnt) <= DEPTH));

  p_full_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(stat_byte[6] && stat_byte[0]));
endmodule

bind host_mbox_port hmp_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
  .host_rd(host_rd), .host_rdata(host_rdata), .dev_in_push(dev_in_push),
  .dev_out_pop(dev_out_pop), .dev_mb_wr(dev_mb_wr), .dev_mb_rd(dev_mb_rd),
  .glob_en(glob_en), .irq(irq), .board_rst(board_rst), .stat_byte(stat_byte),
  .in_cnt(in_cnt), .out_cnt(out_cnt)
);

// File: tb/tb_host_mbox_port.sv
module tb_host_mbox_port;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic        host_wr = 1'b0, host_rd = 1'b0, host_wide = 1'b0;
  logic [15:0] host_rdata;
  logic        board_rst;
  logic        dev_in_push = 1'b0;
  logic [15:0] dev_in_data = '0;
  logic        dev_in_full;
  logic        dev_out_pop = 1'b0;
  logic [15:0] dev_out_data;
  logic        dev_out_empty;
  logic        dev_mb_wr = 1'b0;
  logic [5:0]  dev_mb_wdata = '0;
  logic        dev_mb_rd = 1'b0;
  logic [5:0]  dev_mb_rdata;
  logic        dev_mb_out_full, dev_mb_in_full;
  logic        dev_irq_arm = 1'b0;
  logic        irq;

  int n_vec = 0;
  int n_bad = 0;
  logic [15:0] rv;

  always #(CLK_PERIOD / 2) clk = ~clk;

  host_mbox_port #(.DEPTH(DEPTH), .WORD_MODE(1)) dut (.*);

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FIFO/MBOX FAIL %s: got 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic hwr(logic [2:0] a, logic [15:0] d, logic wide);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wide = wide; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0; host_wide = 1'b0;
  endtask

  task automatic hrd(logic [2:0] a, logic wide, output logic [15:0] d);
    @(negedge clk);
    host_addr = a; host_wide = wide; host_rd = 1'b1;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd = 1'b0; host_wide = 1'b0;
  endtask

  task automatic stat_is(string req, logic [7:0] exp);
    logic [15:0] s;
    hrd(3'd2, 1'b0, s);
    check(req, s, {8'h00, exp});
  endtask

  task automatic dpush(logic [15:0] d);
    @(negedge clk); dev_in_push = 1'b1; dev_in_data = d;
    @(negedge clk); dev_in_push = 1'b0;
  endtask

  task automatic dpop_check(string req, logic [15:0] exp);
    @(negedge clk);
    check(req, dev_out_data, exp);
    dev_out_pop = 1'b1;
    @(negedge clk); dev_out_pop = 1'b0;
  endtask

  task automatic dmb_put(logic [5:0] d);
    @(negedge clk); dev_mb_wr = 1'b1; dev_mb_wdata = d;
    @(negedge clk); dev_mb_wr = 1'b0;
  endtask

  task automatic dmb_take();
    @(negedge clk); dev_mb_rd = 1'b1;
    @(negedge clk); dev_mb_rd = 1'b0;
  endtask

  task automatic darm();
    @(negedge clk); dev_irq_arm = 1'b1;
    @(negedge clk); dev_irq_arm = 1'b0;
  endtask

  task automatic t_reset();
    stat_is("R1 status", 8'h21);
    check("R1 irq", {15'd0, irq}, 16'd0);
    check("R1 board_rst", {15'd0, board_rst}, 16'd0);
    check("R1 mailbox flags", {14'd0, dev_mb_out_full, dev_mb_in_full}, 16'd0);
  endtask

  task automatic t_out_fifo();
    hwr(3'd0, 16'h1234, 1'b1);
    hwr(3'd1, 16'h00AB, 1'b0);
    hwr(3'd0, 16'h0056, 1'b0);
    stat_is("R2 half", 8'h30);
    hwr(3'd0, 16'h0001, 1'b1);
    hwr(3'd0, 16'h0002, 1'b1);
    stat_is("R2 full", 8'h70);
    hwr(3'd0, 16'hDEAD, 1'b1);
    stat_is("R11 still full", 8'h70);
    dpop_check("R2 first", 16'h1234);
    dpop_check("R4 staged upper byte", 16'hAB56);
    dpop_check("R2 third", 16'h0001);
    dpop_check("R11 overflow dropped", 16'h0002);
    stat_is("R2 empty", 8'h21);
    @(negedge clk); dev_out_pop = 1'b1;
    @(negedge clk); dev_out_pop = 1'b0;
    stat_is("R11 pop on empty", 8'h21);
  endtask

  task automatic t_in_fifo();
    logic [15:0] d;
    dpush(16'h1111); dpush(16'h2222); dpush(16'h3333); dpush(16'h4444);
    stat_is("R3 full", 8'h0B);
    check("R3 dev_in_full", {15'd0, dev_in_full}, 16'd1);
    hrd(3'd0, 1'b1, d); check("R3 word read", d, 16'h1111);
    hrd(3'd0, 1'b0, d); check("R4 byte read truncates", d, 16'h0022);
    hrd(3'd0, 1'b1, d); check("R4 next entry after byte read", d, 16'h3333);
    stat_is("R3 one left", 8'h01);
    hrd(3'd0, 1'b1, d); check("R3 last", d, 16'h4444);
    stat_is("R3 empty", 8'h21);
  endtask

  task automatic t_mbox();
    logic [15:0] d;
    hwr(3'd3, 16'h00FF, 1'b0);
    stat_is("R5 out full", 8'hA1);
    check("R5 dev data", {10'd0, dev_mb_rdata}, 16'h003F);
    dmb_take();
    stat_is("R5 cleared", 8'h21);
    hwr(3'd3, 16'h005C, 1'b0);
    check("R5 dev data 2", {10'd0, dev_mb_rdata}, 16'h0017);
    dmb_take();
    dmb_put(6'h2A);
    stat_is("R6 in full", 8'h25);
    hrd(3'd3, 1'b0, d); check("R6 host read", d, 16'h00A8);
    stat_is("R6 cleared", 8'h21);
    check("R6 dev flag", {15'd0, dev_mb_in_full}, 16'd0);
  endtask

  task automatic t_readsel();
    logic [15:0] d;
    hwr(3'd3, 16'h00C4, 1'b0);
    dmb_put(6'h05);
    hwr(3'd2, 16'h0080, 1'b0);
    hrd(3'd3, 1'b0, d); check("R7 outbound readback", d, 16'h00C4);
    stat_is("R7 no clear", 8'hA5);
    hwr(3'd2, 16'h0000, 1'b0);
    hrd(3'd3, 1'b0, d); check("R7 inbound readback", d, 16'h0014);
    stat_is("R7 inbound cleared", 8'hA1);
    dmb_take();
  endtask

  task automatic t_irq();
    hwr(3'd2, 16'h0001, 1'b0);
    check("R8 gated off", {15'd0, irq}, 16'd0);
    darm();
    check("R8 out empty source", {15'd0, irq}, 16'd1);
    hwr(3'd2, 16'h0012, 1'b0);
    check("R12 reserved bits", {15'd0, irq}, 16'd0);
    hwr(3'd2, 16'h0008, 1'b0);
    check("R8 in empty source", {15'd0, irq}, 16'd1);
    hwr(3'd2, 16'h0040, 1'b0);
    check("R8 mailbox idle", {15'd0, irq}, 16'd0);
    dmb_put(6'h01);
    check("R8 in mailbox source", {15'd0, irq}, 16'd1);
    hwr(3'd2, 16'h0020, 1'b0);
    check("R8 in not full", {15'd0, irq}, 16'd0);
    dpush(16'h0A0A); dpush(16'h0B0B); dpush(16'h0C0C); dpush(16'h0D0D);
    check("R8 in full source", {15'd0, irq}, 16'd1);
  endtask

  task automatic t_board_reset();
    hwr(3'd3, 16'h0004, 1'b0);
    @(negedge clk);
    host_addr = 3'd7; host_wdata = 16'h5A5A; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
    check("R9 board_rst pulse", {15'd0, board_rst}, 16'd1);
    check("R9 irq off", {15'd0, irq}, 16'd0);
    check("R9 mailboxes", {14'd0, dev_mb_out_full, dev_mb_in_full}, 16'd0);
    @(negedge clk);
    check("R9 pulse ends", {15'd0, board_rst}, 16'd0);
    stat_is("R9 status", 8'h21);
    hwr(3'd2, 16'h0001, 1'b0);
    check("R9 global enable dropped", {15'd0, irq}, 16'd0);
    darm();
    check("R9 rearmed", {15'd0, irq}, 16'd1);
  endtask

  task automatic t_nop();
    logic [15:0] d;
    dmb_put(6'h01);
    dpush(16'h7777);
    stat_is("R10 before", 8'h05);
    hrd(3'd7, 1'b0, d); check("R10 read data", d, 16'h0000);
    stat_is("R10 after", 8'h05);
    hrd(3'd0, 1'b1, d); check("R10 fifo intact", d, 16'h7777);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_bad++;
    $display("FIFO/MBOX FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_out_fifo();
    t_in_fifo();
    t_mbox();
    t_readsel();
    t_irq();
    t_board_reset();
    t_nop();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule